// File: doc/BRIEF.md
# Step-Driven Timebase With Error Recovery

This block holds one core's 64-bit timebase. It starts out waiting for a time-of-day value. The first load strobe copies that value into the counter and sets it running. From then on the count goes up by one on each step pulse from the time-of-day logic and never on its own. A free-running clock does not advance it.

Five error inputs report faults. Any fault raises a maintenance interrupt, and the interrupt is copied to every thread of the core. Two kinds of fault stop the counter and mark its value untrustworthy:
- a parity or residue fault in the timebase itself;
- a fault in the timer management control.

Parity faults in the decrementer, the hypervisor decrementer or the utilisation counters only interrupt, and the timebase keeps counting. Recovery takes two steps. A clear command first drops the stop and the pending faults. A fresh time-of-day load then resynchronises the counter and sets it running again.

A 3-bit resync summary records three things: that a recovery load has happened, and which decrementers lost their value. The summary leaves on a small valid/ready port. `sum_valid_o` is high whenever any bit is set. A beat is taken when `sum_ready_i` is high in the same cycle, and taking it clears the bits. Holding ready low is back-pressure: the bits stay set and further events are merged into them by OR. An event that arrives in the very cycle a beat is taken survives into the next beat.

Top module: `timebase_resync`

## Requirements
- R1: After reset the counter reads 0, `valid_o`, `running_o`, `irq_o`, `sum_o` and `sum_valid_o` are all 0, and the block is waiting for a load.
- R2: While waiting for a load, a cycle with `tod_load_i` high and no stopping fault copies `tod_value_i` into `tb_o`. `valid_o` and `running_o` read 1 from the next cycle.
- R3: While running, each cycle with `step_i` high and no stopping fault adds exactly 1 to `tb_o`, wrapping from all-ones to zero. Without `step_i` the value holds.
- R4: While not running, `step_i` has no effect and `valid_o` reads 0. Outside the waiting state, `tod_load_i` has no effect.
- R5: Error bit 0 (timebase parity/residue) and bit 1 (timer management control) are stopping faults. Either one, in any state, makes `running_o` and `valid_o` 0 from the next cycle and freezes `tb_o`. A step pulse in the same cycle is not counted.
- R6: Error bits 2 (decrementer), 3 (hypervisor decrementer) and 4 (utilisation) are non-stopping faults. A running counter keeps running and keeps counting steps.
- R7: Any error bit makes every bit of `irq_o` 1 from the next cycle. All threads always see the same level. The interrupt stays until a `clear_i`, and a fault present in the cycle of the clear keeps it set.
- R8: `clear_i` while stopped, with no stopping fault in that cycle, moves the block to waiting for a load. In any other state `clear_i` leaves the state unchanged.
- R9: Summary bit 0 is set by a load that ends a recovery (a load after a clear), but not by the first load after reset. Bit 1 is set by error bit 2, and bit 2 is set by error bit 3.
- R10: `sum_valid_o` is 1 exactly when `sum_o` is non-zero. A beat taken with `sum_ready_i` clears the summary, except for bits set by events in that same cycle. While `sum_ready_i` is 0 the bits are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Step pulse from time-of-day logic |
| tod_value_i | input | 64 | Time-of-day value to load |
| tod_load_i | input | 1 | Load strobe for `tod_value_i` |
| err_i | input | 5 | Fault inputs: 0 timebase parity/residue, 1 timer control, 2 decrementer, 3 hypervisor decrementer, 4 utilisation |
| clear_i | input | 1 | Clear faults / begin recovery |
| sum_ready_i | input | 1 | Consumer takes the summary beat |
| tb_o | output | 64 | Timebase value |
| valid_o | output | 1 | Timebase value is trustworthy |
| running_o | output | 1 | Counter is advancing on steps |
| irq_o | output | 4 | Maintenance interrupt, one per thread |
| sum_o | output | 3 | Resync summary: 0 resynced, 1 decrementer lost, 2 hypervisor decrementer lost |
| sum_valid_o | output | 1 | Summary beat available |

## Verification
The counter is driven with several step patterns and each tells a different fault apart:
- Back-to-back steps catch double counting or dropped increments.
- Sparse steps separate a step-driven count from one that follows the clock.
- A load near all-ones exposes a missing wrap.

Each stopping fault is raised together with a step, which shows whether the fault wins over the increment. Loads and steps given while stopped or waiting show whether a halted counter leaks. Clears coinciding with new faults, and summary reads coinciding with new events, show whether the same-cycle set-over-clear ordering holds. The very first load shows whether a startup load is wrongly reported as a resync.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  typedef enum logic [1:0] {
    TBR_RUN  = 2'd0,
    TBR_HALT = 2'd1,
    TBR_WAIT = 2'd2
  } tbr_state_e;

  localparam int ERR_W  = 5;
  localparam int E_TB   = 0;
  localparam int E_CTL  = 1;
  localparam int E_DEC  = 2;
  localparam int E_HDEC = 3;
  localparam int E_UTIL = 4;

  localparam int SUM_W    = 3;
  localparam int S_RESYNC = 0;
  localparam int S_DEC    = 1;
  localparam int S_HDEC   = 2;
endpackage

// File: rtl/tbr_seq_ctrl.sv
module tbr_seq_ctrl
  import tbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_err,
  input  logic       clear,
  input  logic       load,
  output tbr_state_e state_o,
  output logic       load_ok,
  output logic       resync_done
);
  tbr_state_e state_q;
  logic       recov_q;

  assign state_o     = state_q;
  assign load_ok     = (state_q == TBR_WAIT) && load && !stop_err;
  assign resync_done = load_ok && recov_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TBR_WAIT;
      recov_q <= 1'b0;
    end else if (stop_err) begin
      state_q <= TBR_HALT;
    end else begin
      unique case (state_q)
        TBR_HALT: if (clear) begin
          state_q <= TBR_WAIT;
          recov_q <= 1'b1;
        end
        TBR_WAIT: if (load) begin
          state_q <= TBR_RUN;
          recov_q <= 1'b0;
        end
        default: state_q <= state_q;
      endcase
    end
  end
endmodule

// File: rtl/tbr_count.sv
module tbr_count #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_ok,
  input  logic         load_ok,
  input  logic [W-1:0] value,
  output logic [W-1:0] tb
);
  logic [W-1:0] tb_q;
  assign tb = tb_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tb_q <= '0;
    else if (load_ok) tb_q <= value;
    else if (step_ok) tb_q <= tb_q + W'(1);
  end
endmodule

// File: rtl/tbr_err_track.sv
module tbr_err_track #(
  parameter int             EW        = 5,
  parameter int             N_THR     = 4,
  parameter logic [EW-1:0]  STOP_MASK = 5'b00011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EW-1:0]    err,
  input  logic             clear,
  output logic             stop_err,
  output logic [N_THR-1:0] irq
);
  logic [EW-1:0] pend_q;
  logic          any_pend;

  assign stop_err = |(err & STOP_MASK);
  assign any_pend = |pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (clear ? '0 : pend_q) | err;
  end

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    assign irq[t] = any_pend;
  end
endmodule

// File: rtl/tbr_summary.sv
module tbr_summary #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set,
  input  logic          ready,
  output logic [SW-1:0] sum,
  output logic          valid
);
  logic [SW-1:0] sum_q;
  logic          take;

  assign sum   = sum_q;
  assign valid = |sum_q;
  assign take  = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= (take ? '0 : sum_q) | set;
  end
endmodule

// File: rtl/timebase_resync.sv
module timebase_resync
  import tbr_pkg::*;
#(
  parameter int                W         = 64,
  parameter int                N_THR     = 4,
  parameter logic [ERR_W-1:0]  STOP_MASK = 5'b00011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [W-1:0]      tod_value_i,
  input  logic              tod_load_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              clear_i,
  input  logic              sum_ready_i,
  output logic [W-1:0]      tb_o,
  output logic              valid_o,
  output logic              running_o,
  output logic [N_THR-1:0]  irq_o,
  output logic [SUM_W-1:0]  sum_o,
  output logic              sum_valid_o
);
  tbr_state_e       cur_state;
  logic             stop_err;
  logic             load_ok;
  logic             resync_done;
  logic             running;
  logic             step_ok;
  logic [SUM_W-1:0] sum_set;

  assign running   = (cur_state == TBR_RUN);
  assign step_ok   = running && step_i && !stop_err;
  assign valid_o   = running;
  assign running_o = running;

  always_comb begin
    sum_set           = '0;
    sum_set[S_RESYNC] = resync_done;
    sum_set[S_DEC]    = err_i[E_DEC];
    sum_set[S_HDEC]   = err_i[E_HDEC];
  end

  tbr_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_err    (stop_err),
    .clear       (clear_i),
    .load        (tod_load_i),
    .state_o     (cur_state),
    .load_ok     (load_ok),
    .resync_done (resync_done)
  );

  tbr_count #(.W(W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_ok (step_ok),
    .load_ok (load_ok),
    .value   (tod_value_i),
    .tb      (tb_o)
  );

  tbr_err_track #(.EW(ERR_W), .N_THR(N_THR), .STOP_MASK(STOP_MASK)) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .err      (err_i),
    .clear    (clear_i),
    .stop_err (stop_err),
    .irq      (irq_o)
  );

  tbr_summary #(.SW(SUM_W)) u_sum (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (sum_set),
    .ready (sum_ready_i),
    .sum   (sum_o),
    .valid (sum_valid_o)
  );
endmodule

// File: rtl/timebase_resync_chk.sv
module timebase_resync_chk
  import tbr_pkg::*;
#(
  parameter int               W         = 64,
  parameter int               N_THR     = 4,
  parameter logic [ERR_W-1:0] STOP_MASK = 5'b00011
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_i,
  input logic [W-1:0]      tod_value_i,
  input logic              tod_load_i,
  input logic [ERR_W-1:0]  err_i,
  input logic              clear_i,
  input logic              sum_ready_i,
  input logic [W-1:0]      tb_o,
  input logic              valid_o,
  input logic              running_o,
  input logic [N_THR-1:0]  irq_o,
  input logic [SUM_W-1:0]  sum_o,
  input logic              sum_valid_o,
  input tbr_state_e        cur_state
);
  logic stop_now;
  assign stop_now = |(err_i & STOP_MASK);

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == TBR_WAIT) && tod_load_i && !stop_now |=> running_o && (tb_o == $past(tod_value_i))); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    running_o && step_i && !stop_now |=> tb_o == $past(tb_o) + W'(1)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o && !tod_load_i |=> $stable(tb_o)); // R4
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> !valid_o && !running_o); // R5
  AST_SOFT_ERR_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    running_o && (|err_i) && !stop_now |=> running_o); // R6
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_i) |=> (&irq_o)); // R7
  AST_CLEAR_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == TBR_HALT) && clear_i && !stop_now |=> cur_state == TBR_WAIT); // R8
  AST_SUM_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    err_i[E_DEC] |=> sum_o[S_DEC]); // R9
  AST_SUM_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid_o && sum_ready_i && !err_i[E_DEC] && !err_i[E_HDEC] &&
    !((cur_state == TBR_WAIT) && tod_load_i) |=> sum_o == '0); // R10
  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_ready_i |=> (sum_o & $past(sum_o)) == $past(sum_o)); // R10
endmodule

bind timebase_resync timebase_resync_chk #(.W(W), .N_THR(N_THR), .STOP_MASK(STOP_MASK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_i      (step_i),
  .tod_value_i (tod_value_i),
  .tod_load_i  (tod_load_i),
  .err_i       (err_i),
  .clear_i     (clear_i),
  .sum_ready_i (sum_ready_i),
  .tb_o        (tb_o),
  .valid_o     (valid_o),
  .running_o   (running_o),
  .irq_o       (irq_o),
  .sum_o       (sum_o),
  .sum_valid_o (sum_valid_o),
  .cur_state   (cur_state)
);

// File: tb/timebase_resync_tb.sv
`timescale 1ns/100ps
module timebase_resync_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic [63:0] tod_value_i = '0;
  logic        tod_load_i = 1'b0;
  logic [4:0]  err_i = '0;
  logic        clear_i = 1'b0;
  logic        sum_ready_i = 1'b0;
  logic [63:0] tb_o;
  logic        valid_o, running_o, sum_valid_o;
  logic [3:0]  irq_o;
  logic [2:0]  sum_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  // reference model state: mode 0 running, 1 stopped, 2 waiting
  int          m_mode = 2;
  logic [63:0] m_tb = '0;
  bit          m_pend = 0;
  bit          m_recov = 0;
  logic [2:0]  m_sum = '0;

  always #2.5 clk = ~clk;

  timebase_resync u_dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .tod_value_i(tod_value_i),
    .tod_load_i(tod_load_i), .err_i(err_i), .clear_i(clear_i),
    .sum_ready_i(sum_ready_i), .tb_o(tb_o), .valid_o(valid_o),
    .running_o(running_o), .irq_o(irq_o), .sum_o(sum_o), .sum_valid_o(sum_valid_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit stop, resync;
    cycles++;
    if (!rst_n) begin
      m_mode = 2; m_tb = '0; m_pend = 0; m_recov = 0; m_sum = '0;
    end else begin
      stop = err_i[0] || err_i[1];
      resync = 0;
      if (stop) m_mode = 1;
      else if (m_mode == 0 && step_i) m_tb = m_tb + 64'd1;
      else if (m_mode == 1 && clear_i) begin m_mode = 2; m_recov = 1; end
      else if (m_mode == 2 && tod_load_i) begin
        m_tb = tod_value_i; m_mode = 0; resync = m_recov; m_recov = 0;
      end
      m_pend = (clear_i ? 1'b0 : m_pend) || (err_i != 0);
      if (m_sum != 0 && sum_ready_i) m_sum = '0;
      m_sum = m_sum | {err_i[3], err_i[2], resync};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 tb_o", tb_o, m_tb);
      chk("R4 valid_o", {63'd0, valid_o}, {63'd0, m_mode == 0});
      chk("R5 running_o", {63'd0, running_o}, {63'd0, m_mode == 0});
      chk("R7 irq_o", {60'd0, irq_o}, {60'd0, {4{m_pend}}});
      chk("R9 sum_o", {61'd0, sum_o}, {61'd0, m_sum});
      chk("R10 sum_valid_o", {63'd0, sum_valid_o}, {63'd0, m_sum != 0});
    end
  end

  // one clock of stimulus; returns 1ns after the edge so results are visible
  task automatic cyc(input bit st, input bit ld, input logic [63:0] v,
                     input logic [4:0] e, input bit cl, input bit rd);
    step_i = st; tod_load_i = ld; tod_value_i = v; err_i = e;
    clear_i = cl; sum_ready_i = rd;
    @(posedge clk); #1;
    step_i = 0; tod_load_i = 0; err_i = '0; clear_i = 0; sum_ready_i = 0;
  endtask

  initial begin
    fork
      begin : watchdog
        wait (cycles > 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 tb", tb_o, 64'd0);
    chk("R1 flags", {60'd0, valid_o, running_o, sum_valid_o, |irq_o}, 64'd0);
    chk("R1 sum", {61'd0, sum_o}, 64'd0);

    // R4 steps ignored while waiting
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0);
    chk("R4 wait step", tb_o, 64'd0);

    // R2 startup load; R9 no resync bit on startup
    cyc(0, 1, 64'h1000, 0, 0, 0);
    chk("R2 load value", tb_o, 64'h1000);
    chk("R2 running", {63'd0, running_o}, 64'd1);
    chk("R9 startup no resync", {61'd0, sum_o}, 64'd0);

    // R3 back-to-back and sparse steps
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(i % 3 == 0, 0, 0, 0, 0, 0);
    chk("R3 count", tb_o, 64'h1007);

    // R4 load ignored while running
    cyc(0, 1, 64'hDEAD, 0, 0, 0);
    chk("R4 run load ignored", tb_o, 64'h1007);

    // R6 soft faults keep counting; R7 irq; R9 dec bit
    cyc(1, 0, 0, 5'b00100, 0, 0);
    chk("R6 dec step", tb_o, 64'h1008);
    chk("R7 irq all", {60'd0, irq_o}, 64'hF);
    cyc(1, 0, 0, 5'b10000, 0, 0);
    chk("R6 util step", tb_o, 64'h1009);
    chk("R9 dec lost", {61'd0, sum_o}, 64'b010);
    // R10 held without ready, then drained
    cyc(0, 0, 0, 0, 0, 0);
    chk("R10 hold", {61'd0, sum_o}, 64'b010);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R10 drain", {61'd0, sum_o}, 64'd0);
    // R8 clear while running: still running, irq dropped
    cyc(0, 0, 0, 0, 1, 0);
    chk("R8 run clear", {63'd0, running_o}, 64'd1);
    chk("R7 cleared", {60'd0, irq_o}, 64'd0);

    // R5 stopping fault beats step
    cyc(1, 0, 0, 5'b00001, 0, 0);
    chk("R5 frozen", tb_o, 64'h1009);
    chk("R5 invalid", {63'd0, valid_o}, 64'd0);
    cyc(1, 1, 64'h55, 0, 0, 0);
    chk("R4 halt ignores", tb_o, 64'h1009);
    // R8 clear with new stopping fault stays stopped, irq kept
    cyc(0, 0, 0, 5'b00010, 1, 0);
    chk("R7 clear+fault", {60'd0, irq_o}, 64'hF);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R7 cleared2", {60'd0, irq_o}, 64'd0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R4 wait step2", tb_o, 64'h1009);
    // R9 resync load near wrap, R3 wrap
    cyc(0, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 0);
    chk("R9 resync bit", {61'd0, sum_o}, 64'b001);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R3 wrap", tb_o, 64'd0);
    // R10 drain with same-cycle hdec event survives
    cyc(1, 0, 0, 5'b01000, 0, 1);
    chk("R10 set wins", {61'd0, sum_o}, 64'b100);
    // R5 fault while waiting, then recovery
    cyc(0, 0, 0, 5'b00010, 0, 1);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 1, 64'h77, 5'b00001, 0, 0);
    chk("R5 load blocked", tb_o, 64'd1);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 1, 64'h77, 0, 0, 0);
    chk("R2 reload", tb_o, 64'h77);
    repeat (4) cyc(0, 0, 0, 0, 0, 1);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule